// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects level-sensitive interrupt inputs from peripherals. It selects the pending, unmasked source with the highest programmed priority. It raises a request to the processor together with that source's 4-bit priority level. When the processor acknowledges, the block latches the fixed vector code of the winning source for the processor to read.

Priorities are set per group rather than per source. Each 16-bit priority register holds four 4-bit level fields. A build-time table assigns every source to one field, so several related sources, such as the events of one serial channel, can share a single level. Individual sources are masked through two write-only registers at separate addresses: one register sets mask bits and the other clears them. Software therefore never needs a read-modify-write to change a mask.

The request and the level follow the inputs combinationally. Only the vector code and the programmed state are held in flip-flops.

Top module: `prioVecIntc`

## Requirements
- R1: After reset every priority field is 0, every mask bit is clear, `irqReq` is 0, `irqLevel` is 0 and `vecCode` is 0.
- R2: A write to address r, where r is below the number of priority registers (2 by default), loads bits [4k+3:4k] of `wrData` into level field 4r+k, for k from 0 to 3. Bits 31:16 of that write are unused.
- R3: Each source takes its level from the field that the `SRC_GROUP` table assigns it. In the default table, sources 0 to 3 map to fields 0 to 3, sources 4 to 7 share field 4, sources 8 to 11 share field 5, sources 12 and 13 share field 6, and sources 14 and 15 share field 7.
- R4: A source whose field holds 0 never causes a request, whatever its input level.
- R5: Among pending, unmasked sources with a nonzero level, the highest level wins and `irqLevel` reports it. When levels are equal, the lowest source index wins.
- R6: A write to address 2 (mask-set) masks every source whose bit in `wrData` is 1. Bits written as 0 leave their mask bits unchanged.
- R7: A write to address 3 (mask-clear) unmasks every source whose bit in `wrData` is 1. Bits written as 0 leave their mask bits unchanged.
- R8: Source inputs are level-sensitive. `irqReq` and `irqLevel` change in the same cycle as `srcIn`, the mask or the levels, with no register in between. The request drops as soon as the winning input falls.
- R9: On a clock edge where `irqAck` and `irqReq` are both high, `vecCode` becomes `VEC_BASE` + 0x20 × winning source index, with `VEC_BASE` = 0x400 by default. At all other edges `vecCode` holds its value.
- R10: Writes to addresses 4 to 7 change neither the levels nor the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Level-sensitive interrupt inputs, one per source |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | 32 | Register write data |
| irqAck | input | 1 | Processor acknowledge; latches the vector code |
| irqReq | output | 1 | Interrupt request to the processor |
| irqLevel | output | 4 | Level of the winning source, 0 when idle |
| vecCode | output | VEC_W | Vector code latched at the last acknowledge |

## Verification
`irqReq` and `irqLevel` are due in the same cycle as the stimulus. The bench drives inputs just after a falling edge and compares these two outputs one time step later, before the next rising edge. Register writes and acknowledges take effect at the following rising edge. The bench updates its model at that edge, and `vecCode` is compared at the falling edge after it, one cycle after the acknowledge. The combinational outputs seen in the next cycle then reflect the new levels or mask.

// File: rtl/prioVecIntcPkg.sv
package prioVecIntcPkg;

  // Control-to-datapath strobes for one cycle
  typedef struct packed {
    logic       priWr;    // load one priority register
    logic [3:0] priReg;   // which priority register
    logic       maskSet;  // OR data into the mask
    logic       maskClr;  // clear mask bits where data is 1
    logic       vecLoad;  // capture the winning vector code
  } icStrobe_t;

endpackage

// File: rtl/icControl.sv
module icControl
  import prioVecIntcPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NPRI   = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              irqAck,
  input  logic              irqReq,
  output icStrobe_t         strb
);

  localparam logic [ADDR_W-1:0] SetAddr = ADDR_W'(NPRI);
  localparam logic [ADDR_W-1:0] ClrAddr = ADDR_W'(NPRI + 1);

  always_comb begin
    strb         = '0;
    strb.priWr   = wrEn && (wrAddr < SetAddr);
    strb.priReg  = 4'(wrAddr);
    strb.maskSet = wrEn && (wrAddr == SetAddr);
    strb.maskClr = wrEn && (wrAddr == ClrAddr);
    strb.vecLoad = irqAck && irqReq;
  end

endmodule

// File: rtl/icDatapath.sv
module icDatapath
  import prioVecIntcPkg::*;
#(
  parameter int                    NUM_SRC   = 16,
  parameter int                    NUM_GRP   = 8,
  parameter logic [NUM_SRC*4-1:0]  SRC_GROUP = 64'h7766_5555_4444_3210,
  parameter int                    VEC_BASE  = 'h400,
  parameter int                    VEC_W     = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [31:0]        wrData,
  input  icStrobe_t          strb,
  output logic               irqReq,
  output logic [3:0]         irqLevel,
  output logic [VEC_W-1:0]   vecCode,
  output logic [NUM_SRC-1:0] maskVec
);

  localparam int IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int GRP_IDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

  logic [3:0]         priQ   [NUM_GRP];
  logic [3:0]         srcPri [NUM_SRC];
  logic [NUM_SRC-1:0] maskQ;
  logic [3:0]         bestLvl;
  logic [IDX_W-1:0]   bestIdx;
  logic [VEC_W-1:0]   vecQ;

  // Level storage: field k of register r drives group 4r+k
  for (genvar g = 0; g < NUM_GRP; g++) begin : gPri
    always_ff @(posedge clk) begin
      if (!rstN)
        priQ[g] <= '0;
      else if (strb.priWr && strb.priReg == 4'(g / 4))
        priQ[g] <= wrData[4*(g%4) +: 4];
    end
  end

  // Each source looks up its shared group field
  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    assign srcPri[i] = priQ[SRC_GROUP[4*i +: GRP_IDX_W]];
  end

  // Mask set/clear pair
  always_ff @(posedge clk) begin
    if (!rstN)
      maskQ <= '0;
    else if (strb.maskSet)
      maskQ <= maskQ | wrData[NUM_SRC-1:0];
    else if (strb.maskClr)
      maskQ <= maskQ & ~wrData[NUM_SRC-1:0];
  end

  // Arbitration: strict compare keeps the lowest index on ties
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (srcIn[i] && !maskQ[i] && srcPri[i] > bestLvl) begin
        bestLvl = srcPri[i];
        bestIdx = IDX_W'(i);
      end
    end
  end

  // Vector latched on acknowledge
  always_ff @(posedge clk) begin
    if (!rstN)
      vecQ <= '0;
    else if (strb.vecLoad)
      vecQ <= VEC_W'(VEC_BASE) + (VEC_W'(bestIdx) << 5);
  end

  assign irqReq   = (bestLvl != 4'd0);
  assign irqLevel = bestLvl;
  assign vecCode  = vecQ;
  assign maskVec  = maskQ;

endmodule

// File: rtl/prioVecIntc.sv
module prioVecIntc
  import prioVecIntcPkg::*;
#(
  parameter int                    NUM_SRC   = 16,
  parameter int                    NUM_GRP   = 8,
  parameter logic [NUM_SRC*4-1:0]  SRC_GROUP = 64'h7766_5555_4444_3210,
  parameter int                    VEC_BASE  = 'h400,
  parameter int                    VEC_W     = 12,
  parameter int                    ADDR_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [31:0]        wrData,
  input  logic               irqAck,
  output logic               irqReq,
  output logic [3:0]         irqLevel,
  output logic [VEC_W-1:0]   vecCode
);

  localparam int NPRI = (NUM_GRP + 3) / 4;

  icStrobe_t          strb;
  logic [NUM_SRC-1:0] maskVec;

  icControl #(.ADDR_W(ADDR_W), .NPRI(NPRI)) u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .irqAck (irqAck),
    .irqReq (irqReq),
    .strb   (strb)
  );

  icDatapath #(
    .NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .SRC_GROUP(SRC_GROUP),
    .VEC_BASE(VEC_BASE), .VEC_W(VEC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .wrData   (wrData),
    .strb     (strb),
    .irqReq   (irqReq),
    .irqLevel (irqLevel),
    .vecCode  (vecCode),
    .maskVec  (maskVec)
  );

endmodule

// File: rtl/icChecker.sv
module icChecker #(
  parameter int NUM_SRC  = 16,
  parameter int NUM_GRP  = 8,
  parameter int VEC_BASE = 'h400,
  parameter int VEC_W    = 12,
  parameter int ADDR_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [31:0]        wrData,
  input logic               irqAck,
  input logic               irqReq,
  input logic [3:0]         irqLevel,
  input logic [VEC_W-1:0]   vecCode,
  input logic [NUM_SRC-1:0] maskVec
);

  localparam int NPRI = (NUM_GRP + 3) / 4;
  localparam logic [ADDR_W-1:0] SetA = ADDR_W'(NPRI);
  localparam logic [ADDR_W-1:0] ClrA = ADDR_W'(NPRI + 1);

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == SetA) |=>
      ((maskVec & $past(wrData[NUM_SRC-1:0])) == $past(wrData[NUM_SRC-1:0]))); // R6

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ClrA) |=>
      ((maskVec & $past(wrData[NUM_SRC-1:0])) == '0)); // R7

  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrAddr == SetA || wrAddr == ClrA)) |=> $stable(maskVec)); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((srcIn & ~maskVec) == '0) |-> (!irqReq && irqLevel == 4'd0)); // R8

  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(irqAck && irqReq) |=> $stable(vecCode)); // R9

  AST_VEC_GRID: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq) |=>
      (vecCode[4:0] == 5'd0 && vecCode >= VEC_W'(VEC_BASE))); // R9

endmodule

bind prioVecIntc icChecker #(
  .NUM_SRC(NUM_SRC), .NUM_GRP(NUM_GRP), .VEC_BASE(VEC_BASE),
  .VEC_W(VEC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .irqAck(irqAck), .irqReq(irqReq), .irqLevel(irqLevel),
  .vecCode(vecCode), .maskVec(maskVec)
);

// File: tb/test_prioVecIntc.sv
module test_prioVecIntc;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] srcIn;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [31:0] wrData;
  logic        irqAck;
  logic        irqReq;
  logic [3:0]  irqLevel;
  logic [11:0] vecCode;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // Reference state
  int grpTbl[16] = '{0,1,2,3,4,4,4,4,5,5,5,5,6,6,7,7};
  int levelM[8];
  bit [15:0] maskM;
  int vecM;

  always #5 clk = ~clk;

  prioVecIntc i_prioVecIntc (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .irqAck(irqAck), .irqReq(irqReq), .irqLevel(irqLevel),
    .vecCode(vecCode)
  );

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Drives one cycle and compares every output against the model
  task automatic cyc(input logic [15:0] s, input bit we, input int a,
                     input int d, input bit ack, input string tag);
    int best;
    int idx;
    srcIn = s; wrEn = we; wrAddr = 3'(a); wrData = d; irqAck = ack;
    #1;
    best = 0; idx = 0;
    for (int i = 0; i < 16; i++)
      if (s[i] && !maskM[i] && levelM[grpTbl[i]] > best) begin
        best = levelM[grpTbl[i]]; idx = i;
      end
    check(tag, "irqReq", int'(irqReq), int'(best != 0));
    check(tag, "irqLevel", int'(irqLevel), best);
    @(posedge clk);
    if (we) begin
      if (a < 2)
        for (int k = 0; k < 4; k++) levelM[a*4+k] = (d >> (4*k)) & 'hf;
      else if (a == 2) maskM = maskM | d[15:0];
      else if (a == 3) maskM = maskM & ~d[15:0];
    end
    if (ack && best != 0) vecM = 'h400 + idx * 'h20;
    @(negedge clk);
    check(tag, "vecCode", int'(vecCode), vecM);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    bit [31:0] lf;
    rstN = 1'b0; srcIn = '0; wrEn = 0; wrAddr = '0; wrData = '0; irqAck = 0;
    for (int g = 0; g < 8; g++) levelM[g] = 0;
    maskM = '0; vecM = 0;
    repeat (3) @(negedge clk);
    check("R1", "reset irqReq", int'(irqReq), 0);
    check("R1", "reset irqLevel", int'(irqLevel), 0);
    check("R1", "reset vecCode", int'(vecCode), 0);
    rstN = 1'b1;
    // R1/R4: all levels 0 after reset, so nothing requests
    cyc(16'hffff, 0, 0, 0, 1, "R1");
    // R2: register 0 fields -> groups 0..3
    cyc(16'h0000, 1, 0, 'hffff_4321, 0, "R2");
    cyc(16'h0001, 0, 0, 0, 1, "R2");
    cyc(16'h000f, 0, 0, 0, 1, "R5");
    cyc(16'h0006, 0, 0, 0, 1, "R5");
    // R2/R3: register 1 -> group4=5, group5=0, group6=A, group7=0
    cyc(16'h0000, 1, 1, 'h0a05, 0, "R2");
    cyc(16'h00f0, 0, 0, 0, 1, "R3");
    cyc(16'h00a0, 0, 0, 0, 1, "R5");
    cyc(16'h0f00, 0, 0, 0, 1, "R4");
    cyc(16'hc000, 0, 0, 0, 1, "R4");
    cyc(16'h3000, 0, 0, 0, 1, "R3");
    // R6/R7: mask set then clear
    cyc(16'h3000, 1, 2, 'h1000, 0, "R6");
    cyc(16'h3000, 0, 0, 0, 1, "R6");
    cyc(16'h3000, 1, 2, 'h0000, 0, "R6");
    cyc(16'h3000, 0, 0, 0, 1, "R6");
    cyc(16'h3000, 1, 3, 'h0000, 0, "R7");
    cyc(16'h3000, 0, 0, 0, 0, "R7");
    cyc(16'h3000, 1, 3, 'h1000, 0, "R7");
    cyc(16'h3000, 0, 0, 0, 1, "R7");
    // R10: unused addresses change nothing
    for (int a = 4; a < 8; a++) cyc(16'h30f0, 1, a, 'hffff_ffff, 0, "R10");
    cyc(16'h30f0, 0, 0, 0, 0, "R10");
    cyc(16'hffff, 0, 0, 0, 0, "R10");
    // R8: request follows the inputs in the same cycle
    cyc(16'h0008, 0, 0, 0, 0, "R8");
    cyc(16'h0000, 0, 0, 0, 0, "R8");
    // R9: acknowledge without request keeps the vector
    cyc(16'h0000, 0, 0, 0, 1, "R9");
    cyc(16'h0100, 0, 0, 0, 1, "R9");
    // Mixed sweep
    lf = 32'h1ace_b00c;
    for (int n = 0; n < 300; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (lf[27:25] == 3'd0)
        cyc(lf[15:0], 1, int'(lf[30:28]) % 4, int'(lf[23:16]) * 'h101, lf[24], "R5");
      else
        cyc(lf[15:0], 0, 0, 0, lf[24], "R5");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule